// File: doc/BRIEF.md
# PCI Broadcast Message Listener

This block sits on a PCI bus as a silent observer and picks out the broadcast command that carries system messages to every interested device at once. It watches the framing, initiator-ready, command/byte-enable and address/data lines on the bus clock. It has no output towards the bus, so it can never claim a transaction or drive a target handshake. No target answers a broadcast, so it ends only when the initiator gives up. The listener therefore looks only at the initiator's side of the handshake.

During the first data phase that the initiator marks ready, the listener splits the 32-bit data word. The low half is the message number and the high half is payload whose meaning depends on the message. It then raises a one-cycle message strobe and keeps the two halves on its outputs until the next message. It also raises a dedicated one-cycle pulse for the processor Shutdown and processor Halt messages. The address phase of a broadcast carries nothing useful, so its address/data contents are discarded.

Top module: `pci_bcast_rx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `msg_valid`, `halt_pulse` and `shutdown_pulse` are low and `msg_code` and `msg_data` are zero.
- R2: A transaction is a broadcast when `cbe_n` equals 4'b0001 in its address phase. The address phase is the first clock with `frame_n` low after a clock where `frame_n` and `irdy_n` were both high. `msg_valid` is high for exactly the one cycle that follows the capturing clock edge.
- R3: A transaction with any other command in its address phase produces no strobe or pulse and leaves `msg_code` and `msg_data` unchanged.
- R4: The value on `ad` during the address phase of a broadcast has no effect on `msg_code` or `msg_data`.
- R5: Capture happens on the first clock edge of the broadcast, after its address phase, at which `irdy_n` is low. Wait-state clocks with `irdy_n` high are skipped.
- R6: A captured code of 16'h0000 (Shutdown) raises `shutdown_pulse` in the same cycle as `msg_valid`, and `halt_pulse` stays low.
- R7: A captured code of 16'h0001 (Halt) raises `halt_pulse` in the same cycle as `msg_valid`, and `shutdown_pulse` stays low.
- R8: After a capture, `msg_code` holds `ad[15:0]` and `msg_data` holds `ad[31:16]` from the capturing edge. Both stay stable until the next capture. Any other code raises only `msg_valid`.
- R9: After a capture, further clocks with `irdy_n` low are ignored until `frame_n` and `irdy_n` have both been sampled high. Each broadcast is reported exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | Transaction framing, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| cbe_n | input | 4 | Command in address phase, byte enables in data phase |
| ad | input | 32 | Multiplexed address/data bus |
| msg_valid | output | 1 | One-cycle strobe for each received broadcast |
| halt_pulse | output | 1 | One-cycle pulse for the Halt message |
| shutdown_pulse | output | 1 | One-cycle pulse for the Shutdown message |
| msg_code | output | 16 | Last captured message number |
| msg_data | output | 16 | Last captured message payload |

## Verification
The hardest case to reach from the ports is a master abort, where the initiator keeps `irdy_n` low for several clocks and `ad` keeps changing. In that case only the first ready clock may be reported. Each stimulus vector holds `irdy_n` low for three clocks and changes `ad` on the second and third. The bench then counts strobes across the whole transaction and expects exactly one, carrying the first word. Vectors also insert wait states before the ready clock and place Halt-like or Shutdown-like values on `ad` in the address phase. This shows that neither the wait states nor the address contents leak into the capture.

// File: rtl/pci_bcast_rx.sv
module pci_bcast_rx #(
  parameter int          AD_W          = 32,
  parameter logic [3:0]  BCAST_CMD     = 4'b0001,
  parameter logic [15:0] SHUTDOWN_CODE = 16'h0000,
  parameter logic [15:0] HALT_CODE     = 16'h0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic [3:0]        cbe_n,
  input  logic [AD_W-1:0]   ad,
  output logic              msg_valid,
  output logic              halt_pulse,
  output logic              shutdown_pulse,
  output logic [AD_W/2-1:0] msg_code,
  output logic [AD_W/2-1:0] msg_data
);

  localparam int HALF = AD_W / 2;

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_SKIP, S_DONE} state_t;

  state_t state, nxt;
  logic   bus_idle;
  logic   capture;

  assign bus_idle = frame_n && irdy_n;
  assign capture  = (state == S_ARMED) && !irdy_n;

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:  if (!frame_n) nxt = (cbe_n == BCAST_CMD) ? S_ARMED : S_SKIP;
      S_ARMED: if (!irdy_n) nxt = S_DONE;
               else if (frame_n) nxt = S_IDLE;
      S_SKIP,
      S_DONE:  if (bus_idle) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state          <= S_IDLE;
      msg_valid      <= 1'b0;
      halt_pulse     <= 1'b0;
      shutdown_pulse <= 1'b0;
      msg_code       <= '0;
      msg_data       <= '0;
    end else begin
      state          <= nxt;
      msg_valid      <= capture;
      halt_pulse     <= capture && (ad[HALF-1:0] == HALT_CODE);
      shutdown_pulse <= capture && (ad[HALF-1:0] == SHUTDOWN_CODE);
      if (capture) begin
        msg_code <= ad[HALF-1:0];
        msg_data <= ad[AD_W-1:HALF];
      end
    end
  end

  p_one_shot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |=> !msg_valid);

  p_ready_seen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> $past(!irdy_n));

  p_shutdown_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_pulse |-> (msg_valid && msg_code == SHUTDOWN_CODE && !halt_pulse));

  p_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halt_pulse |-> (msg_valid && msg_code == HALT_CODE));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |-> ($stable(msg_code) && $stable(msg_data)));

  p_foreign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SKIP) |=> !msg_valid);

  p_pulses_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({halt_pulse, shutdown_pulse}));

endmodule

// File: tb/pci_bcast_rx_bench.sv
module pci_bcast_rx_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad = '0;
  logic        msg_valid, halt_pulse, shutdown_pulse;
  logic [15:0] msg_code, msg_data;

  always #10 clk = ~clk;

  pci_bcast_rx u_pci_bcast_rx (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .cbe_n(cbe_n), .ad(ad), .msg_valid(msg_valid), .halt_pulse(halt_pulse),
    .shutdown_pulse(shutdown_pulse), .msg_code(msg_code), .msg_data(msg_data)
  );

  typedef struct packed {
    logic [3:0]  cmd;
    logic [31:0] addr;
    logic [1:0]  waits;
    logic [31:0] data;
    logic        exp_valid;
    logic        exp_halt;
    logic        exp_shut;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{4'b0001, 32'hFFFF_0001, 2'd0, 32'h1234_0000, 1'b1, 1'b0, 1'b1},
    '{4'b0001, 32'h0000_0000, 2'd2, 32'hABCD_0001, 1'b1, 1'b1, 1'b0},
    '{4'b0001, 32'h0000_0000, 2'd1, 32'h5555_0002, 1'b1, 1'b0, 1'b0},
    '{4'b0110, 32'h0000_0001, 2'd0, 32'h0000_0001, 1'b0, 1'b0, 1'b0},
    '{4'b0000, 32'h0000_0000, 2'd1, 32'h0000_0000, 1'b0, 1'b0, 1'b0},
    '{4'b0001, 32'h0000_0000, 2'd3, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0},
    '{4'b0111, 32'h9999_0000, 2'd0, 32'h7777_0000, 1'b0, 1'b0, 1'b0}
  };

  int checks = 0;
  int errors = 0;
  int pulses;
  logic seen_halt, seen_shut, mon_en = 1'b0;
  logic [15:0] exp_code = '0, exp_data = '0;

  always @(negedge clk) if (mon_en) begin
    if (msg_valid) pulses++;
    if (halt_pulse) seen_halt = 1'b1;
    if (shutdown_pulse) seen_shut = 1'b1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic broadcast(input vec_t v);
    pulses = 0; seen_halt = 1'b0; seen_shut = 1'b0; mon_en = 1'b1;
    @(negedge clk); frame_n = 1'b0; irdy_n = 1'b1; cbe_n = v.cmd; ad = v.addr;
    for (int w = 0; w < int'(v.waits); w++) begin
      @(negedge clk); frame_n = 1'b0; irdy_n = 1'b1; cbe_n = 4'hF; ad = 32'hDEAD_0001;
    end
    @(negedge clk); frame_n = 1'b1; irdy_n = 1'b0; cbe_n = 4'h0; ad = v.data;
    @(negedge clk); ad = ~v.data;
    @(negedge clk); ad = v.data ^ 32'h0000_0001;
    @(negedge clk); frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF; ad = 32'h0;
    @(negedge clk);
    mon_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", {31'b0, msg_valid}, 32'd0);
    check("R1 halt", {31'b0, halt_pulse}, 32'd0);
    check("R1 shutdown", {31'b0, shutdown_pulse}, 32'd0);
    check("R1 code", {16'b0, msg_code}, 32'd0);
    check("R1 data", {16'b0, msg_data}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {29'b0, msg_valid, halt_pulse, shutdown_pulse}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      broadcast(VEC[i]);
      if (VEC[i].exp_valid) begin
        exp_code = VEC[i].data[15:0];
        exp_data = VEC[i].data[31:16];
      end
      check("R2 R3 R9 strobe count", pulses, {31'b0, VEC[i].exp_valid});
      check("R7 halt", {31'b0, seen_halt}, {31'b0, VEC[i].exp_halt});
      check("R6 shutdown", {31'b0, seen_shut}, {31'b0, VEC[i].exp_shut});
      check("R4 R5 R8 code", {16'b0, msg_code}, {16'b0, exp_code});
      check("R8 data", {16'b0, msg_data}, {16'b0, exp_data});
    end

    // R1: reset in the middle of a broadcast clears everything
    @(negedge clk); frame_n = 1'b0; cbe_n = 4'b0001; ad = 32'h0;
    @(negedge clk); rst_n = 1'b0; frame_n = 1'b1; irdy_n = 1'b0; ad = 32'h4444_0001;
    @(negedge clk); irdy_n = 1'b1; rst_n = 1'b1;
    check("R1 mid reset valid", {31'b0, msg_valid}, 32'd0);
    check("R1 mid reset code", {16'b0, msg_code}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule